// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

A flash program or erase command has been sent and the device is working through it. This block finds out when the device has finished. A start pulse gives it the address to watch and a limit in clock ticks. It then reads that address in back-to-back pairs through a simple request/response read port.

The rule for finishing is simple. When the toggle bit (data bit 6) has the same value in both reads of a pair, the operation is complete. While that bit keeps changing, the device is still busy. The fail bit (data bit 5) means the device has run past its own internal time limit. When it is seen, one more pair is read to confirm: if the toggle bit is still changing, the result is an error, and if it has stopped, the result is success.

A tick counter runs from the start pulse and is checked before each pair. A limit of zero times out at once. A limit of all ones turns the timeout off. The block gives exactly one result, as a single-cycle pulse carrying a two-bit code, and then goes back to idle.

Top module: `toggle_poller`

## Requirements
- R1: A start pulse in idle captures the target address and the tick limit. Every read request carries the captured address. Each request is a single-cycle pulse on `rdReq`, and the next request is not issued before the response to the previous one. Reads are always issued in pairs.
- R2: If data bit 6 is equal in the two responses of a pair, the result is success (code 01) and no further read is issued. All other data bits are ignored.
- R3: If bit 6 differs and bit 5 of the pair's second response is clear, the timeout check is made and, unless it has expired, another pair is read.
- R4: If bit 6 differs and bit 5 of the pair's second response is set, exactly one confirming pair follows with no timeout check before it. If bit 6 is stable in that pair, the result is success (01); if it still differs, the result is error (10).
- R5: A limit of zero gives a timeout result (code 11) with no read issued. `resultValid` rises on the clock edge after the edge that captures start.
- R6: A limit of all ones never times out, however many pairs are needed.
- R7: For any other limit, the elapsed-tick count starts at zero on the start edge and is checked only before a pair is begun. Once it exceeds the limit, the result is timeout (11). A pair already begun is never cut short, and the result comes at least limit+2 edges after the start edge.
- R8: Each poll gives exactly one one-cycle `resultValid` pulse with a nonzero code. `resultCode` reads 00 whenever `resultValid` is low. The block then accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a poll (sampled in idle) |
| targetAddr | input | ADDR_W | Flash address to poll |
| timeoutTicks | input | TIMEOUT_W | Tick limit; 0 = immediate timeout, all ones = no limit |
| rdReq | output | 1 | One-cycle read request |
| rdAddr | output | ADDR_W | Read address |
| rdRespValid | input | 1 | Read data valid strobe |
| rdRespData | input | DATA_W | Read data |
| resultValid | output | 1 | One-cycle result strobe |
| resultCode | output | 2 | 00 ongoing, 01 success, 10 error, 11 timeout |

## Verification
The assertions assume three things about the read port: it returns exactly one `rdRespValid` pulse for each request, the pulse comes at least one cycle after the request, and no response arrives unprompted. They also assume that `start` is raised only while the block is idle. The bench's flash model meets all of these. It answers each request once after a random latency of 1 to 4 cycles, fills the unused data bits with random values, and drives `start` only after the previous result has been seen. Its toggle count and fail-bit onset are picked so that the expected code and read count follow from a pair-by-pair prediction.

// File: rtl/toggle_poll_pkg.sv
package toggle_poll_pkg;

  typedef enum logic [1:0] {
    RES_ONGOING = 2'b00,
    RES_DONE    = 2'b01,
    RES_FAIL    = 2'b10,
    RES_EXPIRED = 2'b11
  } pollResult_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_REQA, ST_WAITA, ST_REQB, ST_WAITB, ST_EVAL, ST_REPORT
  } pollState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic capFirst;
    logic capSecond;
  } pollStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic expired;
    logic stable;
    logic failFlag;
  } pollStatus_t;

endpackage

// File: rtl/toggle_poll_dp.sv
module toggle_poll_dp
  import toggle_poll_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int TIMEOUT_W  = 16,
  parameter int TOGGLE_BIT = 6,
  parameter int FAIL_BIT   = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pollStrobe_t          strobe,
  input  logic [ADDR_W-1:0]    targetAddr,
  input  logic [TIMEOUT_W-1:0] timeoutTicks,
  input  logic [DATA_W-1:0]    rdRespData,
  output logic [ADDR_W-1:0]    rdAddr,
  output pollStatus_t          status
);

  localparam logic [TIMEOUT_W-1:0] LIMIT_INF  = '1;
  localparam logic [TIMEOUT_W-1:0] LIMIT_ZERO = '0;

  logic [ADDR_W-1:0]    addrQ;
  logic [TIMEOUT_W-1:0] limitQ;
  logic [TIMEOUT_W-1:0] elapsedQ;
  logic                 firstTogQ;
  logic                 secondTogQ;
  logic                 secondFailQ;
  logic                 unusedData;

  assign unusedData = ^rdRespData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      limitQ <= '0;
    end else if (strobe.load) begin
      addrQ  <= targetAddr;
      limitQ <= timeoutTicks;
    end
  end

  // saturating tick counter, cleared on start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsedQ <= '0;
    end else if (strobe.load) begin
      elapsedQ <= '0;
    end else if (elapsedQ != LIMIT_INF) begin
      elapsedQ <= elapsedQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstTogQ   <= 1'b0;
      secondTogQ  <= 1'b0;
      secondFailQ <= 1'b0;
    end else begin
      if (strobe.capFirst) begin
        firstTogQ <= rdRespData[TOGGLE_BIT];
      end
      if (strobe.capSecond) begin
        secondTogQ  <= rdRespData[TOGGLE_BIT];
        secondFailQ <= rdRespData[FAIL_BIT];
      end
    end
  end

  assign rdAddr          = addrQ;
  assign status.expired  = (limitQ != LIMIT_INF) &&
                           ((limitQ == LIMIT_ZERO) || (elapsedQ > limitQ));
  assign status.stable   = (firstTogQ == secondTogQ);
  assign status.failFlag = secondFailQ;

  // R7
  elapsed_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> elapsedQ >= $past(elapsedQ));

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(rdAddr));

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import toggle_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rdRespValid,
  input  pollStatus_t status,
  output pollStrobe_t strobe,
  output logic        rdReq,
  output logic        resultValid,
  output logic [1:0]  resultCode
);

  pollState_e  stateQ, stateD;
  pollResult_e codeQ, codeD;
  logic        retryQ, retryD;

  always_comb begin
    stateD = stateQ;
    codeD  = codeQ;
    retryD = retryQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          retryD      = 1'b0;
          stateD      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.expired) begin
          codeD  = RES_EXPIRED;
          stateD = ST_REPORT;
        end else begin
          stateD = ST_REQA;
        end
      end
      ST_REQA: stateD = ST_WAITA;
      ST_WAITA: begin
        if (rdRespValid) begin
          strobe.capFirst = 1'b1;
          stateD          = ST_REQB;
        end
      end
      ST_REQB: stateD = ST_WAITB;
      ST_WAITB: begin
        if (rdRespValid) begin
          strobe.capSecond = 1'b1;
          stateD           = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (status.stable) begin
          codeD  = RES_DONE;
          stateD = ST_REPORT;
        end else if (retryQ) begin
          codeD  = RES_FAIL;
          stateD = ST_REPORT;
        end else if (status.failFlag) begin
          retryD = 1'b1;
          stateD = ST_REQA;
        end else begin
          stateD = ST_CHECK;
        end
      end
      ST_REPORT: stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      codeQ  <= RES_ONGOING;
      retryQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      codeQ  <= codeD;
      retryQ <= retryD;
    end
  end

  assign rdReq       = (stateQ == ST_REQA) || (stateQ == ST_REQB);
  assign resultValid = (stateQ == ST_REPORT);
  assign resultCode  = resultValid ? codeQ : RES_ONGOING;

  // R8
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R8
  code_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> resultCode != RES_ONGOING);

  // R1
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R4
  fail_confirmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultCode == RES_FAIL) |-> retryQ);

endmodule

// File: rtl/toggle_poller.sv
module toggle_poller
  import toggle_poll_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int TIMEOUT_W  = 16,
  parameter int TOGGLE_BIT = 6,
  parameter int FAIL_BIT   = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    targetAddr,
  input  logic [TIMEOUT_W-1:0] timeoutTicks,
  output logic                 rdReq,
  output logic [ADDR_W-1:0]    rdAddr,
  input  logic                 rdRespValid,
  input  logic [DATA_W-1:0]    rdRespData,
  output logic                 resultValid,
  output logic [1:0]           resultCode
);

  pollStrobe_t strobe;
  pollStatus_t dpStatus;

  toggle_poll_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .rdRespValid (rdRespValid),
    .status      (dpStatus),
    .strobe      (strobe),
    .rdReq       (rdReq),
    .resultValid (resultValid),
    .resultCode  (resultCode)
  );

  toggle_poll_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TIMEOUT_W  (TIMEOUT_W),
    .TOGGLE_BIT (TOGGLE_BIT),
    .FAIL_BIT   (FAIL_BIT)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .targetAddr   (targetAddr),
    .timeoutTicks (timeoutTicks),
    .rdRespData   (rdRespData),
    .rdAddr       (rdAddr),
    .status       (dpStatus)
  );

  // R7
  timeout_backed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultCode == RES_EXPIRED) |-> dpStatus.expired);

endmodule

// File: tb/toggle_poller_tb.sv
module toggle_poller_tb_top;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int TW = 10;
  localparam int NEVER = 32'h3FFF_FFFF;
  localparam logic [TW-1:0] INF = '1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] targetAddr = '0;
  logic [TW-1:0] timeoutTicks = '0;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic          rdRespValid = 1'b0;
  logic [DW-1:0] rdRespData = '0;
  logic          resultValid;
  logic [1:0]    resultCode;

  int tests = 0;
  int fails = 0;

  // flash model state
  int            readCnt = 0;
  int            togReads = 0;
  int            failAfter = NEVER;
  int            addrBad = 0;
  int            respCnt = 0;
  logic          togBit = 1'b0;
  logic [DW-1:0] pendData = '0;
  logic [AW-1:0] curAddr = '0;

  always #5 clk = ~clk;

  toggle_poller #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_W(TW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .targetAddr(targetAddr),
    .timeoutTicks(timeoutTicks), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdRespValid(rdRespValid), .rdRespData(rdRespData),
    .resultValid(resultValid), .resultCode(resultCode));

  // flash model: toggles bit 6 on each read while busy, bit 5 from a chosen read on
  always @(negedge clk) begin
    rdRespValid = 1'b0;
    if (respCnt > 0) begin
      respCnt = respCnt - 1;
      if (respCnt == 0) begin
        rdRespValid = 1'b1;
        rdRespData  = pendData;
      end
    end
    if (rdReq) begin
      if (rdAddr != curAddr) addrBad = addrBad + 1;
      pendData    = DW'($urandom);
      pendData[6] = togBit;
      pendData[5] = (readCnt >= failAfter);
      if (readCnt < togReads) togBit = ~togBit;
      readCnt = readCnt + 1;
      respCnt = 1 + int'($urandom % 4);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // pair-by-pair prediction for an unlimited timeout
  function automatic void predict(input int t, input int b, output int code, output int reads);
    bit retry = 1'b0;
    code = 0;
    reads = 0;
    for (int i = 0; i < 4000; i++) begin
      bit tg = (2 * i < t);
      bit fl = (2 * i + 1 >= b);
      if (!tg) begin code = 1; reads = 2 * (i + 1); return; end
      if (retry) begin code = 2; reads = 2 * (i + 1); return; end
      if (fl) retry = 1'b1;
    end
  endfunction

  task automatic runPoll(input logic [AW-1:0] addr, input logic [TW-1:0] lim,
                         input int t, input int b, input int expCode, input int expReads,
                         input int latLo, input int latHi, input string req);
    int lat = 0;
    bit seen = 1'b0;
    readCnt = 0; togReads = t; failAfter = b; addrBad = 0;
    togBit = 1'($urandom);
    curAddr = addr;
    targetAddr = addr;
    timeoutTicks = lim;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!resultValid && lat < 6000) begin
      @(negedge clk);
      lat = lat + 1;
    end
    seen = resultValid;
    chk(seen, req, "result seen before watchdog", lat, latHi);
    chk(int'(resultCode) == expCode, req, "result code", resultCode, expCode);
    if (expReads >= 0)
      chk(readCnt == expReads, req, "read count", readCnt, expReads);
    else
      chk(readCnt % 2 == 0, req, "reads in whole pairs", readCnt % 2, 0);
    chk(lat >= latLo && lat <= latHi, req, "result latency", lat, latLo);
    chk(addrBad == 0, "R1", "reads at target address", addrBad, 0);
    @(negedge clk);
    chk(!resultValid && resultCode == 2'b00, "R8", "single pulse then ongoing code",
        {resultValid, resultCode}, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int code;
    int reads;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!rdReq && !resultValid && resultCode == 2'b00, "R8", "reset outputs",
        {rdReq, resultValid, resultCode}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: already finished, one pair
    runPoll(24'h00_0AAA, INF, 0, NEVER, 1, 2, 3, 40, "R2");
    // R3: several busy pairs then done
    predict(9, NEVER, code, reads);
    runPoll(24'h12_3456, INF, 9, NEVER, code, reads, 3, 400, "R3");
    // R5: zero limit
    runPoll(24'h00_0100, '0, NEVER, NEVER, 3, 0, 2, 2, "R5");
    // R4: fail bit while toggling forever -> error after one confirm pair
    predict(NEVER, 5, code, reads);
    runPoll(24'h55_0000, INF, NEVER, 5, 2, reads, 3, 400, "R4");
    // R4: fail bit then toggling stops in confirm pair -> success
    runPoll(24'h55_0002, INF, 8, 7, 1, 10, 3, 400, "R4");
    // R6: long busy period beyond the limit range
    runPoll(24'h7F_FFFF, INF, 400, NEVER, 1, 402, 1024, 6000, "R6");
    // R7: finite limits with a device that never finishes
    runPoll(24'h00_0040, TW'(1), NEVER, NEVER, 3, -1, 4, 22, "R7");
    for (int i = 0; i < 6; i++) begin
      int lim = 10 + int'($urandom % 140);
      runPoll(AW'($urandom), TW'(lim), NEVER, NEVER, 3, -1, lim + 2, lim + 20, "R7");
    end
    // random mix under an unlimited timeout
    for (int i = 0; i < 30; i++) begin
      int t = int'($urandom % 20);
      int b = ($urandom % 3 == 0) ? NEVER : int'($urandom % 24);
      predict(t, b, code, reads);
      runPoll(AW'($urandom), INF, t, b, code, reads, 3, 600,
              (code == 2) ? "R4" : "R2");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests = tests + 1;
    fails = fails + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule